// File: doc/BRIEF.md
# Segmented Address Generation Unit

This unit turns a segment slot number and an effective offset into a linear address. It runs in one of two modes. A single mode input selects the mode, and the mode can change from one cycle to the next. In real mode it shifts the slot's 16-bit selector left by four bits and adds the low 16 bits of the offset. The result is a 20-bit address with no protection check. In protected mode it adds the offset to a 32-bit base taken from a shadow descriptor held for that slot. It then compares the offset with the slot's limit, and an offset past the limit raises a fault instead of producing an address.

There are six slots: one for code, one for stack and four for data. Each slot holds a selector and a shadow descriptor. Both are written together through a load port. The load port takes a selector and an 8-byte descriptor, and the unit unpacks the descriptor into base, limit and attribute fields on the next rising clock edge. Translation is purely combinational from the request inputs to the outputs. Fetching descriptors from tables in memory is left to the surrounding logic.

Top module: `seg_agu`

## Requirements
- R1: In real mode (`prot_mode`=0) with a valid slot, `lin_addr` is ((selector << 4) + `xl_offset`[15:0]) mod 2^20, zero-extended to 32 bits. `xl_offset`[31:16] are ignored. `lin_valid`=1 and `fault`=0.
- R2: In protected mode with a valid slot and the offset within the limit, `lin_addr` is (base + `xl_offset`) mod 2^32 and `lin_valid`=1.
- R3: In protected mode, an offset strictly greater than the effective limit sets `fault`=1 and `lin_valid`=0, and `lin_addr` and `lin_attr` read 0. An offset equal to the limit is allowed.
- R4: Descriptor bit 55 is the granularity flag. When it is set, the effective limit is (limit << 12) | 0xFFF. When it is clear, the effective limit is the 20-bit limit.
- R5: The descriptor is unpacked as follows. The base is {bits 63:56, bits 39:16}. The limit is {bits 51:48, bits 15:0}. The attributes are {bits 55:52, bits 47:40}.
- R6: A load is written on the rising edge at which `ld_en` is high. A translation in the same cycle still sees the slot's previous contents.
- R7: The slots are independent of one another. A load with `ld_seg` 6 or 7 changes no slot.
- R8: A request with `xl_seg` 6 or 7 sets `fault`=1 and `lin_valid`=0 in either mode.
- R9: With `xl_valid`=0, the outputs `lin_addr`, `lin_attr`, `lin_valid` and `fault` are all 0.
- R10: Reset clears every selector, base, limit and attribute to 0. After reset, a real-mode address equals the offset's low 16 bits, and a protected access faults for any offset above 0.
- R11: On a successful protected translation, `lin_attr` gives the slot's 12 attribute bits. In real mode `lin_attr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prot_mode | input | 1 | 1 = protected, 0 = real |
| ld_en | input | 1 | Write selector and descriptor into slot `ld_seg` |
| ld_seg | input | 3 | Slot to load |
| ld_sel | input | 16 | Selector value |
| ld_desc | input | 64 | Packed 8-byte descriptor |
| xl_valid | input | 1 | Translate request |
| xl_seg | input | 3 | Slot used by the request |
| xl_offset | input | 32 | Effective offset |
| lin_addr | output | 32 | Linear address |
| lin_attr | output | 12 | Attributes of the slot used |
| lin_valid | output | 1 | Address is usable |
| fault | output | 1 | Limit violation or bad slot |

## Verification
Three slots are loaded with contrasting descriptors: a mid-memory base with a byte-granular limit, a base near the top of memory with a page-granular limit, and a zero base with a zero limit. Each slot is then probed in both modes at its exact limit and at one past it. These probes separate a correct greater-than comparison from an off-by-one, and they show whether granularity scaling and 32-bit wrap are applied. Real-mode probes use offsets with junk in the upper half and selectors near the top of the range, which exposes a missing 16-bit truncation or missing 20-bit wrap. Directed tests then look at descriptor bit scattering, the load-versus-translate ordering in a single cycle, loads to non-existent slots, and idle outputs.

// File: rtl/seg_agu_pkg.sv
`timescale 1ns/1ps
package seg_agu_pkg;
  localparam int DESC_W = 64;
  localparam int SEL_W  = 16;
  localparam int BASE_W = 32;
  localparam int LIM_W  = 20;
  localparam int ATTR_W = 12;
  localparam int REAL_W = 20;
  localparam int PAGE_SH = 12;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [LIM_W-1:0]  limit;
    logic [ATTR_W-1:0] attr;   // {flags nibble, access byte}; attr[11] = granularity
  } shadow_t;

  function automatic shadow_t unpack_desc(input logic [DESC_W-1:0] d);
    shadow_t s;
    s.base  = {d[63:56], d[39:16]};
    s.limit = {d[51:48], d[15:0]};
    s.attr  = {d[55:52], d[47:40]};
    return s;
  endfunction

  function automatic logic [BASE_W-1:0] eff_limit(input shadow_t s);
    if (s.attr[ATTR_W-1])
      return {s.limit, {PAGE_SH{1'b1}}};
    return {{(BASE_W-LIM_W){1'b0}}, s.limit};
  endfunction

  function automatic logic [REAL_W-1:0] real_addr(input logic [SEL_W-1:0] sel,
                                                  input logic [SEL_W-1:0] off);
    return {sel, 4'h0} + {4'h0, off};
  endfunction

  function automatic logic [BASE_W-1:0] prot_addr(input logic [BASE_W-1:0] base,
                                                  input logic [BASE_W-1:0] off);
    return base + off;
  endfunction
endpackage

// File: rtl/seg_agu_shadow.sv
`timescale 1ns/1ps
module seg_agu_shadow
  import seg_agu_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int IDX_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [DESC_W-1:0] ld_desc,
  output logic [SEL_W-1:0]  sel_q [NUM_SEG],
  output shadow_t           shd_q [NUM_SEG]
);
  shadow_t unpacked;
  assign unpacked = unpack_desc(ld_desc);

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_slot
    logic hit;
    assign hit = ld_en && (ld_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[g] <= '0;
        shd_q[g] <= '0;
      end else if (hit) begin
        sel_q[g] <= ld_sel;
        shd_q[g] <= unpacked;
      end
    end
  end
endmodule

// File: rtl/seg_agu_xlate.sv
`timescale 1ns/1ps
module seg_agu_xlate
  import seg_agu_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int IDX_W   = 3
) (
  input  logic              prot_mode,
  input  logic              req,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BASE_W-1:0] off,
  input  logic [SEL_W-1:0]  sel_q [NUM_SEG],
  input  shadow_t           shd_q [NUM_SEG],
  output logic              idx_bad,
  output logic              over_limit,
  output logic [BASE_W-1:0] addr,
  output logic [ATTR_W-1:0] attr,
  output logic              valid,
  output logic              flt
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SEG - 1);

  logic [SEL_W-1:0] sel_s;
  shadow_t          shd_s;

  always_comb begin
    sel_s = '0;
    shd_s = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (idx == IDX_W'(i)) begin
        sel_s = sel_q[i];
        shd_s = shd_q[i];
      end
    end
  end

  assign idx_bad    = idx > LAST;
  assign over_limit = off > eff_limit(shd_s);

  always_comb begin
    addr  = '0;
    attr  = '0;
    valid = 1'b0;
    flt   = 1'b0;
    if (req) begin
      if (idx_bad) begin
        flt = 1'b1;
      end else if (!prot_mode) begin
        valid = 1'b1;
        addr  = {{(BASE_W-REAL_W){1'b0}}, real_addr(sel_s, off[SEL_W-1:0])};
      end else if (over_limit) begin
        flt = 1'b1;
      end else begin
        valid = 1'b1;
        addr  = prot_addr(shd_s.base, off);
        attr  = shd_s.attr;
      end
    end
  end
endmodule

// File: rtl/seg_agu.sv
`timescale 1ns/1ps
module seg_agu
  import seg_agu_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int IDX_W   = $clog2(NUM_SEG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_mode,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_seg,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [DESC_W-1:0] ld_desc,
  input  logic              xl_valid,
  input  logic [IDX_W-1:0]  xl_seg,
  input  logic [BASE_W-1:0] xl_offset,
  output logic [BASE_W-1:0] lin_addr,
  output logic [ATTR_W-1:0] lin_attr,
  output logic              lin_valid,
  output logic              fault
);
  logic [SEL_W-1:0] sel_q [NUM_SEG];
  shadow_t          shd_q [NUM_SEG];
  logic             idx_bad;
  logic             over_limit;

  seg_agu_shadow #(.NUM_SEG(NUM_SEG), .IDX_W(IDX_W)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (ld_en),
    .ld_idx  (ld_seg),
    .ld_sel  (ld_sel),
    .ld_desc (ld_desc),
    .sel_q   (sel_q),
    .shd_q   (shd_q)
  );

  seg_agu_xlate #(.NUM_SEG(NUM_SEG), .IDX_W(IDX_W)) u_xlate (
    .prot_mode  (prot_mode),
    .req        (xl_valid),
    .idx        (xl_seg),
    .off        (xl_offset),
    .sel_q      (sel_q),
    .shd_q      (shd_q),
    .idx_bad    (idx_bad),
    .over_limit (over_limit),
    .addr       (lin_addr),
    .attr       (lin_attr),
    .valid      (lin_valid),
    .flt        (fault)
  );
endmodule

// File: rtl/seg_agu_chk.sv
`timescale 1ns/1ps
module seg_agu_chk #(
  parameter int NUM_SEG = 6,
  parameter int IDX_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             prot_mode,
  input logic             ld_en,
  input logic [IDX_W-1:0] xl_seg,
  input logic             xl_valid,
  input logic [31:0]      xl_offset,
  input logic [31:0]      lin_addr,
  input logic [11:0]      lin_attr,
  input logic             lin_valid,
  input logic             fault,
  input logic             idx_bad,
  input logic             over_limit
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SEG - 1);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_valid |-> (!lin_valid && !fault && lin_addr == 32'h0 && lin_attr == 12'h0));

  a_r3_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid |-> (lin_valid != fault));

  a_r8_bad_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && xl_seg > LAST) |-> (fault && !lin_valid));

  a_r1_real_range: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && !prot_mode && !idx_bad) |-> (lin_valid && lin_addr[31:20] == 12'h0 && lin_attr == 12'h0));

  a_r3_limit_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && prot_mode && !idx_bad && over_limit) |-> (fault && lin_addr == 32'h0));

  a_r6_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ld_en) && $stable(xl_valid) && $stable(xl_seg) && $stable(xl_offset) && $stable(prot_mode))
      |-> ($stable(lin_addr) && $stable(fault)));
endmodule

bind seg_agu seg_agu_chk #(.NUM_SEG(NUM_SEG), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .prot_mode  (prot_mode),
  .ld_en      (ld_en),
  .xl_seg     (xl_seg),
  .xl_valid   (xl_valid),
  .xl_offset  (xl_offset),
  .lin_addr   (lin_addr),
  .lin_attr   (lin_attr),
  .lin_valid  (lin_valid),
  .fault      (fault),
  .idx_bad    (idx_bad),
  .over_limit (over_limit)
);

// File: tb/seg_agu_tb.sv
`timescale 1ns/1ps
module seg_agu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prot_mode = 1'b0;
  logic        ld_en = 1'b0;
  logic [2:0]  ld_seg = '0;
  logic [15:0] ld_sel = '0;
  logic [63:0] ld_desc = '0;
  logic        xl_valid = 1'b0;
  logic [2:0]  xl_seg = '0;
  logic [31:0] xl_offset = '0;
  logic [31:0] lin_addr;
  logic [11:0] lin_attr;
  logic        lin_valid;
  logic        fault;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  seg_agu u_dut (
    .clk(clk), .rst_n(rst_n), .prot_mode(prot_mode),
    .ld_en(ld_en), .ld_seg(ld_seg), .ld_sel(ld_sel), .ld_desc(ld_desc),
    .xl_valid(xl_valid), .xl_seg(xl_seg), .xl_offset(xl_offset),
    .lin_addr(lin_addr), .lin_attr(lin_attr), .lin_valid(lin_valid), .fault(fault)
  );

  // Packing per R5: base {63:56,39:16}, limit {51:48,15:0}, attrs {55:52,47:40}
  function automatic logic [63:0] mk_desc(input logic [31:0] base, input logic [19:0] lim,
                                          input logic [7:0] acc, input logic [3:0] flg);
    logic [63:0] d;
    d = '0;
    d[15:0]  = lim[15:0];
    d[51:48] = lim[19:16];
    d[39:16] = base[23:0];
    d[63:56] = base[31:24];
    d[47:40] = acc;
    d[55:52] = flg;
    return d;
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_load(input logic [2:0] s, input logic [15:0] sel, input logic [63:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_seg = s; ld_sel = sel; ld_desc = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic probe(input logic p, input logic [2:0] s, input logic [31:0] off);
    prot_mode = p; xl_valid = 1'b1; xl_seg = s; xl_offset = off;
    #1;
  endtask

  typedef struct packed {
    logic        prot;
    logic [2:0]  seg;
    logic [31:0] off;
    logic        ev;
    logic        ef;
    logic [31:0] ea;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 3'd0, 32'h0000_FFFF, 1'b1, 1'b0, 32'h0010_FFFF}, // at limit
    '{1'b1, 3'd0, 32'h0001_0000, 1'b0, 1'b1, 32'h0},         // one past
    '{1'b1, 3'd1, 32'h0000_1FFF, 1'b1, 1'b0, 32'h0000_0FFF}, // page limit, wraps
    '{1'b1, 3'd1, 32'h0000_2000, 1'b0, 1'b1, 32'h0},
    '{1'b1, 3'd2, 32'h0000_0000, 1'b1, 1'b0, 32'h0},
    '{1'b1, 3'd2, 32'h0000_0001, 1'b0, 1'b1, 32'h0},
    '{1'b1, 3'd6, 32'h0000_0000, 1'b0, 1'b1, 32'h0},
    '{1'b0, 3'd0, 32'h0000_0005, 1'b1, 1'b0, 32'h0001_2345},
    '{1'b0, 3'd1, 32'hABCD_FFFF, 1'b1, 1'b0, 32'h0000_FFEF}, // 20-bit wrap
    '{1'b0, 3'd2, 32'h0000_0010, 1'b1, 1'b0, 32'h0000_1010},
    '{1'b0, 3'd0, 32'h0001_0000, 1'b1, 1'b0, 32'h0001_2340}, // limit ignored
    '{1'b0, 3'd7, 32'h0000_0000, 1'b0, 1'b1, 32'h0},
    '{1'b1, 3'd7, 32'h0000_0004, 1'b0, 1'b1, 32'h0}
  };

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: idle outputs all zero
    @(negedge clk);
    xl_valid = 1'b0; #1;
    chk("R9 idle", {lin_addr, lin_attr, lin_valid, fault}, 64'h0);

    // R10: reset contents
    @(negedge clk); probe(1'b0, 3'd3, 32'hFFFF_1234);
    chk("R10 real after reset", {lin_valid, fault, lin_addr}, {1'b1, 1'b0, 32'h0000_1234});
    @(negedge clk); probe(1'b1, 3'd3, 32'h0);
    chk("R10 prot off0", {lin_valid, fault, lin_addr}, {1'b1, 1'b0, 32'h0});
    @(negedge clk); probe(1'b1, 3'd3, 32'h1);
    chk("R10 prot off1", {lin_valid, fault}, {1'b0, 1'b1});
    xl_valid = 1'b0;

    do_load(3'd0, 16'h1234, mk_desc(32'h0010_0000, 20'h0FFFF, 8'h9A, 4'h4));
    do_load(3'd1, 16'hFFFF, mk_desc(32'hFFFF_F000, 20'h00001, 8'h92, 4'hC));
    do_load(3'd2, 16'h0100, mk_desc(32'h0000_0000, 20'h00000, 8'h93, 4'h0));

    for (int i = 0; i < NV; i++) begin
      string tag;
      @(negedge clk);
      probe(VEC[i].prot, VEC[i].seg, VEC[i].off);
      if (VEC[i].seg > 3'd5) tag = "R8";
      else if (!VEC[i].prot) tag = "R1";
      else if (VEC[i].ef) tag = "R3";
      else if (VEC[i].seg == 3'd1) tag = "R4";
      else tag = "R2";
      chk(tag, {lin_valid, fault, lin_addr}, {VEC[i].ev, VEC[i].ef, VEC[i].ea});
    end

    // R11: attributes
    @(negedge clk); probe(1'b1, 3'd0, 32'h10);
    chk("R11 attr slot0", {20'h0, lin_attr}, {20'h0, 12'h49A});
    @(negedge clk); probe(1'b1, 3'd1, 32'h10);
    chk("R11 attr slot1", {20'h0, lin_attr}, {20'h0, 12'hC92});
    @(negedge clk); probe(1'b0, 3'd1, 32'h10);
    chk("R11 attr real", {20'h0, lin_attr}, 32'h0);

    // R5: scattered fields
    xl_valid = 1'b0;
    do_load(3'd4, 16'h0, mk_desc(32'hA1B2_C3D4, 20'hF5678, 8'h92, 4'h0));
    @(negedge clk); probe(1'b1, 3'd4, 32'h0);
    chk("R5 base", {lin_valid, lin_addr}, {1'b1, 32'hA1B2_C3D4});
    @(negedge clk); probe(1'b1, 3'd4, 32'h000F_5678);
    chk("R5 limit edge", {lin_valid, fault}, {1'b1, 1'b0});
    @(negedge clk); probe(1'b1, 3'd4, 32'h000F_5679);
    chk("R5 limit past", {lin_valid, fault}, {1'b0, 1'b1});

    // R6: same-cycle load vs translate
    @(negedge clk);
    ld_en = 1'b1; ld_seg = 3'd2; ld_sel = 16'h0; ld_desc = mk_desc(32'h0000_8000, 20'hFFFFF, 8'h92, 4'h0);
    probe(1'b1, 3'd2, 32'h4);
    chk("R6 before edge", {lin_valid, fault}, {1'b0, 1'b1});
    @(posedge clk); #1;
    chk("R6 after edge", {lin_valid, lin_addr}, {1'b1, 32'h0000_8004});
    @(negedge clk); ld_en = 1'b0;

    // R7: loads to slots 6 and 7 touch nothing; other slots unaffected
    xl_valid = 1'b0;
    do_load(3'd6, 16'hAAAA, mk_desc(32'h5555_0000, 20'h0, 8'h0, 4'h0));
    do_load(3'd7, 16'hBBBB, mk_desc(32'h6666_0000, 20'h0, 8'h0, 4'h0));
    @(negedge clk); probe(1'b1, 3'd5, 32'h0);
    chk("R7 slot5 untouched", {lin_valid, lin_addr}, {1'b1, 32'h0});
    @(negedge clk); probe(1'b0, 3'd5, 32'h7);
    chk("R7 slot5 selector", lin_addr, 32'h7);
    @(negedge clk); probe(1'b1, 3'd0, 32'h0000_FFFF);
    chk("R7 slot0 kept", {lin_valid, lin_addr}, {1'b1, 32'h0010_FFFF});
    @(negedge clk); probe(1'b1, 3'd4, 32'h0);
    chk("R7 slot4 kept", lin_addr, 32'hA1B2_C3D4);

    @(negedge clk); xl_valid = 1'b0; #1;
    chk("R9 idle end", {lin_addr, lin_attr, lin_valid, fault}, 64'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule